// File: doc/BRIEF.md
# Frame-Context Feature Shift Buffer

This block keeps a sliding context window of acoustic feature frames that serves as the input layer of a keyword-spotting network. Every frame period (10 ms) a new group of 13 signed fixed-point coefficients arrives one word at a time on a valid/data input. Once the thirteenth word of a group has arrived, every stored frame moves one slot towards the old end. The oldest group is discarded and the new group takes the newest slot. The window holds 31 frames: the frame under evaluation plus 15 frames on each side of it, for 403 words in total.

A downstream multiply-accumulate engine fetches any stored word through a registered random-access read port, using a flat index. Words are laid out frame-major with the oldest frame first. A fill counter raises `window_full` once enough frames have arrived to populate the whole window, so the engine knows when the context is valid.

Top module: `fcb_context_buf`

## Requirements
- R1: After reset, `window_full` and `rd_valid` are low and every index in 0..402 reads as zero.
- R2: A read requested with `rd_en` high at a clock edge puts the word on `rd_data` and raises `rd_valid` right after that edge, so the result is one cycle later. `rd_valid` is low after any edge at which `rd_en` was low.
- R3: Index `f*13 + c` addresses coefficient `c` (0..12) of frame slot `f` (0..30). Slot 0 is the oldest frame and slot 30 is the newest, at indices 390..402.
- R4: Coefficients are taken one per cycle while `in_valid` is high, in order 0..12. Cycles with `in_valid` low are ignored and do not advance the count. A partly received frame is not visible to reads until its 13th word has been accepted.
- R5: Each completed frame moves every stored frame one slot older. The frame in slot 0 is dropped, so index `f*13+c` then returns what index `(f+1)*13+c` returned before.
- R6: `window_full` rises right after the edge that accepts the 13th word of the 31st frame since reset, and not earlier.
- R7: Once high, `window_full` stays high until reset.
- R8: A read issued in the same cycle as the word that completes a frame returns the data from before that shift.
- R9: A read of an index of 403 or above returns zero, with `rd_valid` raised as usual.
- R10: Each word is a 16-bit two's-complement value in Q2.13 format. It is stored and returned bit-exact, negative values included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A coefficient word is present on `in_data` |
| in_data | input | 16 | Signed Q2.13 coefficient |
| rd_en | input | 1 | Read request |
| rd_idx | input | 9 | Flat word index of the read |
| rd_data | output | 16 | Word returned by the last read |
| rd_valid | output | 1 | `rd_data` holds the result of a read requested at the previous edge |
| window_full | output | 1 | All 31 frame slots have been written since reset |

## Verification
A read result is due exactly one cycle after the request. The driver records the expected word, taken from a reference window in its state before the edge, at the moment it issues the request. A monitor sampling just after each rising edge then consumes one expectation per raised `rd_valid`, and it reports any expectation still pending when `rd_valid` is low. The frame shift and `window_full` both change at the edge that accepts the 13th word. They are therefore checked at the half-cycle after that edge, with `window_full` checked after both frame 30 and frame 31. Reads placed on the completing word, reads of a partly filled frame and reads past the last index each cover one of the timing corners.

// File: rtl/fcb_pkg.sv
package fcb_pkg;
  // Default geometry of the context window
  localparam int unsigned DEF_COEFS  = 13;
  localparam int unsigned DEF_FRAMES = 31;
  localparam int unsigned DEF_WORD_W = 16;

  // Width needed to address n words
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fcb_assemble.sv
// Collects one frame of coefficients serially and presents it in parallel
// together with a one-cycle shift request on the completing word.
module fcb_assemble #(
  parameter int unsigned COEFS  = fcb_pkg::DEF_COEFS,
  parameter int unsigned WORD_W = fcb_pkg::DEF_WORD_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [WORD_W-1:0]       in_data,
  output logic                    frame_go,
  output logic [COEFS*WORD_W-1:0] frame_vec
);
  localparam int unsigned CNT_W = fcb_pkg::idx_width(COEFS);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              last_word;
  logic [WORD_W-1:0] stage_q [COEFS-1];
  logic [WORD_W-1:0] stage_d [COEFS-1];

  assign last_word = (cnt_q == CNT_W'(COEFS - 1));
  assign frame_go  = in_valid && last_word;

  always_comb begin
    cnt_d = cnt_q;
    if (in_valid) begin
      cnt_d = last_word ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < COEFS - 1; g++) begin : g_stage
    always_comb begin
      stage_d[g] = stage_q[g];
      if (in_valid && (cnt_q == CNT_W'(g))) stage_d[g] = in_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d[g];
    end

    assign frame_vec[g*WORD_W +: WORD_W] = stage_q[g];
  end

  // The completing word bypasses staging and enters the window directly
  assign frame_vec[(COEFS-1)*WORD_W +: WORD_W] = in_data;
endmodule

// File: rtl/fcb_window.sv
// Frame-major word storage: shifts a whole frame per request and serves a
// registered indexed read from the pre-shift contents.
module fcb_window #(
  parameter int unsigned COEFS  = fcb_pkg::DEF_COEFS,
  parameter int unsigned FRAMES = fcb_pkg::DEF_FRAMES,
  parameter int unsigned WORD_W = fcb_pkg::DEF_WORD_W,
  parameter int unsigned DEPTH  = COEFS * FRAMES,
  parameter int unsigned IDX_W  = fcb_pkg::idx_width(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    shift_en,
  input  logic [COEFS*WORD_W-1:0] new_frame,
  input  logic                    rd_en,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [WORD_W-1:0]       rd_data,
  output logic                    rd_valid
);
  localparam int unsigned NEW_BASE = DEPTH - COEFS;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] mem_d [DEPTH];
  logic [WORD_W-1:0] rd_data_q, rd_data_d;
  logic              rd_valid_q;
  logic              idx_ok;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    if (i < NEW_BASE) begin : g_old
      assign mem_d[i] = shift_en ? mem_q[i + COEFS] : mem_q[i];
    end else begin : g_new
      assign mem_d[i] = shift_en ? new_frame[(i - NEW_BASE)*WORD_W +: WORD_W] : mem_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[i] <= '0;
      else        mem_q[i] <= mem_d[i];
    end
  end

  assign idx_ok = ({1'b0, rd_idx} < (IDX_W + 1)'(DEPTH));

  always_comb begin
    rd_data_d = rd_data_q;
    if (rd_en) rd_data_d = idx_ok ? mem_q[rd_idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_data_q  <= rd_data_d;
      rd_valid_q <= rd_en;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;
endmodule

// File: rtl/fcb_fill.sv
// Counts completed frames and latches the full flag on the last one.
module fcb_fill #(
  parameter int unsigned FRAMES = fcb_pkg::DEF_FRAMES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_go,
  output logic full
);
  localparam int unsigned CNT_W = fcb_pkg::idx_width(FRAMES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full_q, full_d;

  always_comb begin
    cnt_d  = cnt_q;
    full_d = full_q;
    if (frame_go && !full_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(FRAMES - 1)) full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= full_d;
    end
  end

  assign full = full_q;
endmodule

// File: rtl/fcb_context_buf.sv
module fcb_context_buf #(
  parameter int unsigned COEFS  = fcb_pkg::DEF_COEFS,
  parameter int unsigned FRAMES = fcb_pkg::DEF_FRAMES,
  parameter int unsigned WORD_W = fcb_pkg::DEF_WORD_W,
  parameter int unsigned DEPTH  = COEFS * FRAMES,
  parameter int unsigned IDX_W  = fcb_pkg::idx_width(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              window_full
);
  logic                    frame_go;
  logic [COEFS*WORD_W-1:0] frame_vec;

  fcb_assemble #(.COEFS(COEFS), .WORD_W(WORD_W)) i_assemble (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .frame_go  (frame_go),
    .frame_vec (frame_vec)
  );

  fcb_window #(
    .COEFS(COEFS), .FRAMES(FRAMES), .WORD_W(WORD_W), .DEPTH(DEPTH), .IDX_W(IDX_W)
  ) i_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (frame_go),
    .new_frame (frame_vec),
    .rd_en     (rd_en),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  fcb_fill #(.FRAMES(FRAMES)) i_fill (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_go (frame_go),
    .full     (window_full)
  );
endmodule

// File: rtl/fcb_context_buf_chk.sv
module fcb_context_buf_chk #(
  parameter int unsigned COEFS  = fcb_pkg::DEF_COEFS,
  parameter int unsigned FRAMES = fcb_pkg::DEF_FRAMES,
  parameter int unsigned WORD_W = fcb_pkg::DEF_WORD_W,
  parameter int unsigned DEPTH  = COEFS * FRAMES,
  parameter int unsigned IDX_W  = fcb_pkg::idx_width(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_data,
  input logic              rd_en,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [WORD_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              window_full
);
  localparam int unsigned WC_W = fcb_pkg::idx_width(DEPTH) + 1;

  // Words accepted since reset, saturating
  logic [WC_W-1:0] word_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              word_cnt <= '0;
    else if (in_valid && (word_cnt != '1))   word_cnt <= word_cnt + 1'b1;
  end

  // R2
  rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R2
  rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R9
  out_of_range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ({1'b0, rd_idx} >= (IDX_W + 1)'(DEPTH))) |=> (rd_data == '0));

  // R7
  full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    window_full |=> window_full);

  // R6
  full_on_last_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(window_full) |-> (word_cnt == WC_W'(DEPTH)));

  // R4
  full_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(window_full) |-> $past(in_valid));

  logic unused_ok;
  assign unused_ok = ^in_data;
endmodule

bind fcb_context_buf fcb_context_buf_chk #(
  .COEFS(COEFS), .FRAMES(FRAMES), .WORD_W(WORD_W), .DEPTH(DEPTH), .IDX_W(IDX_W)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_data     (in_data),
  .rd_en       (rd_en),
  .rd_idx      (rd_idx),
  .rd_data     (rd_data),
  .rd_valid    (rd_valid),
  .window_full (window_full)
);

// File: tb/test_fcb_context_buf.sv
`timescale 1ns/1ps
module test_fcb_context_buf;
  localparam int NC = 13;
  localparam int NF = 31;
  localparam int ND = NC * NF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        rd_en = 1'b0;
  logic [8:0]  rd_idx = '0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        window_full;

  always #2.5 clk = ~clk;

  fcb_context_buf i_fcb_context_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid),
    .window_full(window_full)
  );

  typedef struct { logic [15:0] val; string req; int idx; } exp_t;
  exp_t exp_q[$];

  int n_checks = 0;
  int n_fail   = 0;

  // Reference window and frame assembly state
  logic [15:0] ref_mem [ND];
  logic [15:0] ref_stage [NC];
  int ref_cnt = 0;
  int ref_frames = 0;

  function automatic logic [15:0] pat(input int f, input int c);
    logic [15:0] v;
    v = 16'(f * 977 + c * 131 + 7);
    if ((c % 3) == 1) v = v | 16'h8000;   // negative Q2.13 values (R10)
    return v;
  endfunction

  task automatic ref_clear();
    for (int i = 0; i < ND; i++) ref_mem[i] = '0;
    ref_cnt = 0;
    ref_frames = 0;
  endtask

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: one cycle, called at a falling edge, returns at the next one
  task automatic step(input bit v, input logic [15:0] d, input bit r, input int idx,
                      input string req);
    exp_t e;
    in_valid = v;
    in_data  = d;
    rd_en    = r;
    rd_idx   = 9'(idx);
    if (r) begin
      e.val = (idx < ND) ? ref_mem[idx] : 16'h0000;
      e.req = req;
      e.idx = idx;
      exp_q.push_back(e);
    end
    if (v) begin
      ref_stage[ref_cnt] = d;
      if (ref_cnt == NC - 1) begin
        for (int i = 0; i < ND - NC; i++) ref_mem[i] = ref_mem[i + NC];
        for (int c = 0; c < NC; c++) ref_mem[ND - NC + c] = ref_stage[c];
        ref_cnt = 0;
        ref_frames++;
      end else begin
        ref_cnt++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    rd_en    = 1'b0;
  endtask

  task automatic rd(input int idx, input string req);
    step(1'b0, '0, 1'b1, idx, req);
  endtask

  task automatic push_frame(input int f, input bit gaps);
    for (int c = 0; c < NC; c++) begin
      step(1'b1, pat(f, c), 1'b0, 0, "");
      if (gaps && (c % 4 == 2)) step(1'b0, 16'hDEAD, 1'b0, 0, "");   // R4 ignored idle
    end
  endtask

  // Monitor: results are due just after the edge following the request
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (rd_valid) begin
        if (exp_q.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R2: actual=rd_valid high expected=no pending read");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(rd_data, e.val, $sformatf("%s idx %0d", e.req, e.idx));
        end
      end else if (exp_q.size() != 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_checks++; n_fail++;
        $display("FAIL R2 idx %0d: actual=rd_valid low expected=%h", e.idx, e.val);
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    ref_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_tests();
    do_reset();
    // R1: reset state
    check(16'(window_full), 16'h0, "R1 window_full");
    check(16'(rd_valid), 16'h0, "R1 rd_valid");
    rd(0, "R1"); rd(200, "R1"); rd(402, "R1");

    // R4: partial frame with idle gaps stays invisible
    for (int c = 0; c < NC - 1; c++) begin
      step(1'b1, pat(0, c), 1'b0, 0, "");
      step(1'b0, 16'hBEEF, 1'b0, 0, "");
    end
    rd(390, "R4"); rd(401, "R4");
    step(1'b1, pat(0, NC - 1), 1'b0, 0, "");
    // R3: newest frame occupies 390..402
    for (int c = 0; c < NC; c++) rd(390 + c, "R3");

    // Fill up to 30 frames, then the 31st
    for (int f = 1; f < NF - 1; f++) push_frame(f, f[0]);
    check(16'(window_full), 16'h0, "R6 after 30 frames");
    push_frame(NF - 1, 1'b0);
    check(16'(window_full), 16'h1, "R6 after 31 frames");
    // R3 / R10: whole window, frame-major, oldest first, bit-exact signs
    for (int i = 0; i < ND; i++) rd(i, "R3");

    // R8: read on the completing word sees pre-shift data
    for (int c = 0; c < NC - 1; c++) step(1'b1, pat(NF, c), 1'b0, 0, "");
    step(1'b1, pat(NF, NC - 1), 1'b1, 402, "R8");
    // R5: oldest frame dropped, contents moved one slot older
    rd(0, "R5"); rd(12, "R5"); rd(377, "R5"); rd(402, "R5");
    rd(403 - 13 + 1, "R10");
    // R7: stays full across further frames
    push_frame(NF + 1, 1'b1);
    check(16'(window_full), 16'h1, "R7");
    // R9: out-of-range indices
    rd(403, "R9"); rd(511, "R9");
    rd(5, "R5");
    step(1'b0, '0, 1'b0, 0, "");
    step(1'b0, '0, 1'b0, 0, "");

    // R1: a second reset clears everything
    do_reset();
    check(16'(window_full), 16'h0, "R1 after re-reset");
    rd(0, "R1"); rd(402, "R1");
    step(1'b0, '0, 1'b0, 0, "");
    step(1'b0, '0, 1'b0, 0, "");
  endtask

  initial begin
    ref_clear();
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=run complete");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule